// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a two-wire serial EEPROM holding 8192 bytes (64 kbit). It takes the clock and data lines as oversampled inputs, which the system clock samples many times per bus bit. It drives the data line through an open-drain pull-low enable. It detects START and STOP conditions and compares the device address against a fixed prefix plus three strap pins. It then takes a two-byte word address, and either collects write data into a 32-byte page buffer or streams bytes out of the array. The master's acknowledge after each byte decides whether the stream goes on.

Written bytes stay in the page buffer until a STOP arrives on a byte boundary. The whole page is then committed in one modelled programming cycle of a parameterised number of clocks. During that cycle the slave ignores the bus entirely. If the operation is abandoned (an early STOP, a STOP or START inside a byte, or a START before STOP), the buffered bytes are dropped and the array is left as it was. A repeated START after the word address turns the access into a read at that address.

Top module: `twowire_eeprom_slave`

## Requirements
- R1: The slave answers the address byte 1010 followed by `strapIn[2:1:0]` and the R/W bit (R/W = 0 write, 1 read) by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and SDA stays released until the next START.
- R2: In write direction the slave acknowledges the high address byte, the low address byte and every data byte.
- R3: Only the low 13 address bits are used, so the top three bits of the high address byte are ignored. Successive data bytes go to successive 5-bit in-page offsets, and the upper 8 address bits stay fixed.
- R4: When more than 32 data bytes arrive before STOP, the offset wraps to the start of the page. The later byte replaces the earlier one at the same offset, and offsets in the page that were not written keep their old contents.
- R5: The array changes only after a STOP. A write cut short by a START and then a STOP leaves the array unchanged.
- R6: After a committing STOP the slave runs a programming cycle of `PROG_CYCLES` clocks. During it the slave never pulls SDA, not even for its own address.
- R7: In a read the slave sends 8 bits MSB first and releases SDA for the ninth clock. On a master ACK (SDA low) it sends the byte at the next address, and the 13-bit address wraps from 0x1FFF to 0x0000.
- R8: After a master NACK the slave leaves SDA released for all further clocks until a START.
- R9: A repeated START followed by the read address reads from the word address loaded just before.
- R10: A STOP before any data byte, or a STOP in the middle of a byte, writes nothing and starts no programming cycle.
- R11: During and right after reset SDA is released.
- R12: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| strapIn | input | 3 | Strap pins forming the low three device address bits |
| sdaPullLow | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions assume a well-behaved master. It changes SDA only while SCL is low, except for START and STOP. It never issues START or STOP while the slave is pulling SDA. Each SCL level lasts well beyond the two-stage input synchroniser. The stimulus keeps to this by building every bus event from fixed phases of eight clocks. SDA moves in the middle of each low phase, and the master releases SDA whenever the slave is due to drive it. Strap pins are held constant for the whole run.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_WSTOP
  } busState_t;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic wrByte;
    logic rdInc;
    logic commit;
    logic discard;
  } eepStrobe_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/eep_bus_ctrl.sv
module eep_bus_ctrl
  import eep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [2:0] strapIn,
  input  logic       progBusy,
  input  logic [7:0] rdData,
  output eepStrobe_t stb,
  output logic [7:0] rxByte,
  output logic       sdaPullLow
);

  busState_t  state, nextSt;
  logic       sclQ, sdaQ;
  logic [3:0] bitCnt;
  logic [7:0] shReg, txReg;
  logic       ackDrv, txOn, mAck;

  logic sclRise, sclFall, startSeen, stopSeen;
  logic active, byteDone, slotEnd, addrHit, loadTx;

  always_comb begin
    sclRise   = sclS & ~sclQ;
    sclFall   = ~sclS & sclQ;
    startSeen = sclS & sclQ & sdaQ & ~sdaS;
    stopSeen  = sclS & sclQ & ~sdaQ & sdaS;
    active    = (state != ST_IDLE) && (state != ST_WSTOP);
    byteDone  = active && sclFall && (bitCnt == 4'd8);
    slotEnd   = active && sclFall && (bitCnt == 4'd9);
    addrHit   = (shReg[7:1] == {DEV_PREFIX, strapIn});
    loadTx    = slotEnd && (nextSt == ST_RDAT) && !((state == ST_RDAT) && !mAck);
  end

  always_comb begin
    stb = '0;
    if (!progBusy) begin
      if (stopSeen) begin
        if ((state == ST_WDAT) && (bitCnt <= 4'd1)) stb.commit = 1'b1;
        else stb.discard = 1'b1;
      end else if (startSeen) begin
        stb.discard = 1'b1;
      end else if (byteDone) begin
        case (state)
          ST_AHI:  stb.loadHi = 1'b1;
          ST_ALO:  stb.loadLo = 1'b1;
          ST_WDAT: stb.wrByte = 1'b1;
          default: ;
        endcase
      end else if (loadTx) begin
        stb.rdInc = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      state  <= ST_IDLE;
      nextSt <= ST_IDLE;
      bitCnt <= '0;
      shReg  <= '0;
      txReg  <= '0;
      ackDrv <= 1'b0;
      txOn   <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      sclQ <= sclS;
      sdaQ <= sdaS;
      if (progBusy || stopSeen) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        ackDrv <= 1'b0;
        txOn   <= 1'b0;
      end else if (startSeen) begin
        state  <= ST_DEV;
        bitCnt <= '0;
        ackDrv <= 1'b0;
        txOn   <= 1'b0;
      end else if (active) begin
        if (sclRise) begin
          if (bitCnt < 4'd8) shReg <= {shReg[6:0], sdaS};
          if (bitCnt == 4'd8) mAck <= ~sdaS;
          if (bitCnt < 4'd9) bitCnt <= bitCnt + 4'd1;
        end
        if (sclFall) begin
          if (bitCnt == 4'd8) begin
            txOn <= 1'b0;
            case (state)
              ST_DEV: begin
                if (addrHit) begin
                  ackDrv <= 1'b1;
                  nextSt <= shReg[0] ? ST_RDAT : ST_AHI;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_AHI:  begin ackDrv <= 1'b1; nextSt <= ST_ALO;  end
              ST_ALO:  begin ackDrv <= 1'b1; nextSt <= ST_WDAT; end
              ST_WDAT: begin ackDrv <= 1'b1; nextSt <= ST_WDAT; end
              default: nextSt <= ST_RDAT;
            endcase
          end else if (bitCnt == 4'd9) begin
            ackDrv <= 1'b0;
            bitCnt <= '0;
            if ((state == ST_RDAT) && !mAck) state <= ST_WSTOP;
            else state <= nextSt;
            if (loadTx) begin
              txReg <= rdData;
              txOn  <= 1'b1;
            end
          end else if (txOn) begin
            txReg <= {txReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign rxByte     = shReg;
  assign sdaPullLow = ackDrv | (txOn & ~txReg[7]);

  // R12: the drive only moves while the synchronised clock is low
  assert_drive_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclS);

  // R6: nothing is driven while programming
  assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    progBusy |-> !sdaPullLow);

  // R8 / R1: idle and post-NACK states keep SDA released
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) || (state == ST_WSTOP)) |-> !sdaPullLow);

endmodule

// File: rtl/eep_datapath.sv
module eep_datapath
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  eepStrobe_t stb,
  input  logic [7:0] rxByte,
  output logic [7:0] rdData,
  output logic       progBusy
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE   = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);

  logic [7:0]        mem [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   pageValid;
  logic [ADDR_W-1:0] curAddr;
  logic [HI_W-1:0]   hiHold;
  logic [CNT_W-1:0]  progCnt;
  logic [BASE_W-1:0] progBase;
  logic [PAGE_W-1:0] wrOff, walkOff;
  logic              walkWrite;

  assign wrOff     = curAddr[PAGE_W-1:0];
  assign walkOff   = progCnt[PAGE_W-1:0];
  assign walkWrite = progBusy && (progCnt < PAGE_CNT) && pageValid[walkOff];

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.wrByte && (wrOff == PAGE_W'(g))) pageBuf[g] <= rxByte;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pageValid[g] <= 1'b0;
      else if (stb.discard) pageValid[g] <= 1'b0;
      else if (stb.wrByte && (wrOff == PAGE_W'(g))) pageValid[g] <= 1'b1;
      else if (progBusy && (progCnt == CNT_W'(g))) pageValid[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      hiHold   <= '0;
      progBusy <= 1'b0;
      progCnt  <= '0;
      progBase <= '0;
    end else begin
      if (stb.loadHi) hiHold <= rxByte[HI_W-1:0];
      if (stb.loadLo) curAddr <= {hiHold, rxByte};
      else if (stb.wrByte) curAddr[PAGE_W-1:0] <= wrOff + PAGE_W'(1);
      else if (stb.rdInc) curAddr <= curAddr + ADDR_W'(1);
      if (progBusy) begin
        if (progCnt == LAST_CNT) progBusy <= 1'b0;
        else progCnt <= progCnt + CNT_W'(1);
      end else if (stb.commit && (|pageValid)) begin
        progBusy <= 1'b1;
        progCnt  <= '0;
        progBase <= curAddr[ADDR_W-1:PAGE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (walkWrite) mem[{progBase, walkOff}] <= pageBuf[walkOff];
    rdData <= mem[curAddr];
  end

  logic [CNT_W-1:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (progBusy) busyLen <= busyLen + CNT_W'(1);
    else busyLen <= '0;
  end

  // R6: programming lasts exactly the configured number of clocks
  assert_prog_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progBusy) |-> (busyLen == CNT_W'(PROG_CYCLES)));

  // R3: page writes never move the upper address bits
  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrByte |=> (curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W])));

  // R7: sequential reads step the full address with wrap
  assert_read_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdInc |=> (curAddr == $past(curAddr) + ADDR_W'(1)));

  // R10: a commit with an empty buffer starts no programming
  assert_no_empty_prog_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && !progBusy && !(|pageValid)) |=> !progBusy);

endmodule

// File: rtl/twowire_eeprom_slave.sv
module twowire_eeprom_slave
  import eep_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strapIn,
  output logic       sdaPullLow
);

  logic [1:0] pinSync;
  logic       progBusy;
  logic [7:0] rdData, rxByte;
  eepStrobe_t stb;

  eep_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclIn, sdaIn}),
    .dout (pinSync)
  );

  eep_bus_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclS       (pinSync[1]),
    .sdaS       (pinSync[0]),
    .strapIn    (strapIn),
    .progBusy   (progBusy),
    .rdData     (rdData),
    .stb        (stb),
    .rxByte     (rxByte),
    .sdaPullLow (sdaPullLow)
  );

  eep_datapath #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rxByte   (rxByte),
    .rdData   (rdData),
    .progBusy (progBusy)
  );

endmodule

// File: tb/twowire_eeprom_slave_bench.sv
`timescale 1ns/1ps
module twowire_eeprom_slave_bench;

  localparam int PROG = 600;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaPullLow;
  logic line;
  int checks = 0;
  int errors = 0;
  int r12Viol = 0;
  bit done = 0;
  logic [7:0] refMem [0:8191];

  always #2 clk = ~clk;

  assign line = sdaM & ~sdaPullLow;

  twowire_eeprom_slave #(.PROG_CYCLES(PROG)) u_twowire_eeprom_slave (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (line),
    .strapIn    (STRAP),
    .sdaPullLow (sdaPullLow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R12 monitor: drive edges seen while the bus clock stays high
  logic lastDrv = 1'b0;
  logic lastScl = 1'b1;
  always @(negedge clk) begin
    if (rstN && sclM && lastScl && (sdaPullLow != lastDrv)) r12Viol++;
    lastDrv <= sdaPullLow;
    lastScl <= sclM;
  end

  task automatic startCond();
    sdaM = 1'b1; tick(8);
    sclM = 1'b1; tick(8);
    sdaM = 1'b0; tick(8);
    sclM = 1'b0; tick(8);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; tick(8);
    sclM = 1'b1; tick(8);
    sdaM = 1'b1; tick(8);
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaM = b;    tick(8);
    sclM = 1'b1; tick(8);
    s = line;    tick(8);
    sclM = 1'b0; tick(8);
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(d[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(ackIt ? 1'b0 : 1'b1, s);
  endtask

  task automatic sendAddr(input int addr, input logic [2:0] topBits, input string tag);
    bit a;
    sendByte({topBits, 5'(addr >> 8)}, a);
    check(a, {tag, " high address ack"}, a, 1);
    sendByte(8'(addr), a);
    check(a, {tag, " low address ack"}, a, 1);
  endtask

  task automatic writeOp(input int addr, input int n, input int seed, input string tag);
    bit a;
    logic [7:0] pb [32];
    bit pv [32];
    int base;
    for (int k = 0; k < 32; k++) pv[k] = 0;
    base = addr & 13'h1FE0;
    startCond();
    sendByte(DEV_W, a);
    check(a, "R1 own write address ack", a, 1);
    sendAddr(addr, 3'b101, "R2");
    for (int k = 0; k < n; k++) begin
      int off;
      logic [7:0] d;
      d = 8'(seed + 7 * k);
      off = ((addr & 31) + k) % 32;
      sendByte(d, a);
      check(a, {tag, " data byte ack R2"}, a, 1);
      pb[off] = d;
      pv[off] = 1;
    end
    stopCond();
    for (int k = 0; k < 32; k++) if (pv[k]) refMem[base + k] = pb[k];
  endtask

  task automatic readOp(input int addr, input int n, input string tag);
    bit a;
    logic s;
    logic [7:0] d;
    startCond();
    sendByte(DEV_W, a);
    check(a, "R1 own address ack before read", a, 1);
    sendAddr(addr, 3'b000, "R9");
    startCond();
    sendByte(DEV_R, a);
    check(a, "R9 read address ack after repeated START", a, 1);
    for (int k = 0; k < n; k++) begin
      int ra;
      ra = (addr + k) & 13'h1FFF;
      recvByte(k < n - 1, d);
      check(d === refMem[ra], tag, d, refMem[ra]);
    end
    clockBit(1'b1, s);
    check(s == 1'b1, "R8 SDA released after NACK (1)", s, 1);
    clockBit(1'b1, s);
    check(s == 1'b1, "R8 SDA released after NACK (2)", s, 1);
    stopCond();
  endtask

  initial begin
    bit a;
    logic s;
    tick(5);
    check(sdaPullLow == 1'b0, "R11 SDA released in reset", sdaPullLow, 0);
    rstN = 1'b1;
    tick(10);
    check(sdaPullLow == 1'b0, "R11 SDA released after reset", sdaPullLow, 0);

    // single byte write, then poll while programming
    writeOp(13'h0123, 1, 8'h5A, "R3 byte write");
    startCond();
    sendByte(DEV_W, a);
    check(!a, "R6 no ack during programming cycle", a, 0);
    stopCond();
    tick(PROG + 40);
    readOp(13'h0123, 1, "R9 random read of byte write");

    // wrong device address
    startCond();
    sendByte(8'hA0, a);
    check(!a, "R1 foreign address not acknowledged", a, 0);
    sendByte(8'h00, a);
    check(!a, "R1 stays silent after mismatch", a, 0);
    stopCond();

    // page write with wrap (35 bytes from offset 28)
    writeOp(13'h0A5C, 35, 8'h30, "R4 wrapped page");
    tick(PROG + 40);
    readOp(13'h0A40, 32, "R4 page readback");

    // short page write crossing the page end, then neighbours
    writeOp(13'h0A7E, 3, 8'h90, "R3 short page");
    tick(PROG + 40);
    readOp(13'h0A7E, 2, "R3 in-page offsets");
    readOp(13'h0A60, 1, "R3 offset wrap keeps upper bits");

    // untouched bytes keep their value after a later partial write
    writeOp(13'h0A44, 2, 8'hE1, "R4 partial overwrite");
    tick(PROG + 40);
    readOp(13'h0A40, 8, "R4 untouched offsets unchanged");

    // sequential read across the top of the array
    writeOp(13'h1FFF, 1, 8'hC3, "R7 top byte");
    tick(PROG + 40);
    writeOp(13'h0000, 1, 8'h3C, "R7 bottom byte");
    tick(PROG + 40);
    readOp(13'h1FFF, 2, "R7 address wrap 0x1FFF to 0x0000");

    // abort cases on a known location
    writeOp(13'h0300, 1, 8'h11, "R10 setup");
    tick(PROG + 40);

    startCond();
    sendByte(DEV_W, a);
    sendAddr(13'h0300, 3'b000, "R10");
    sendByte(8'h77, a);
    clockBit(1'b1, s);
    clockBit(1'b0, s);
    clockBit(1'b1, s);
    stopCond();
    startCond();
    sendByte(DEV_W, a);
    check(a, "R10 mid-byte STOP starts no programming", a, 1);
    stopCond();

    startCond();
    sendByte(DEV_W, a);
    sendAddr(13'h0300, 3'b000, "R10");
    stopCond();
    startCond();
    sendByte(DEV_W, a);
    check(a, "R10 STOP before data starts no programming", a, 1);
    stopCond();

    startCond();
    sendByte(DEV_W, a);
    sendAddr(13'h0300, 3'b000, "R5");
    sendByte(8'h55, a);
    startCond();
    stopCond();
    tick(20);
    readOp(13'h0300, 1, "R5 R10 aborted writes leave array unchanged");

    check(r12Viol == 0, "R12 drive changes only with SCL low", r12Viol, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule